// File: doc/BRIEF.md
# Noise Sample Collector

This block turns a bank of free-running ring-oscillator noise bits into a stream of raw noise bytes that a later conditioning stage can consume. While it is enabled, every clock it samples all oscillators whose mask bit is set and folds them into one sample bit by XOR. A run of such samples is XOR-compressed into a single bit, and that bit is shifted into a byte register. The length of the run is programmable.

Every eighth shifted bit completes a byte, which is presented with a one-cycle valid strobe. Bytes are grouped into blocks of a parameterised bit size. After a programmable number of blocks, which together make one set, a one-cycle done pulse follows the final byte and counting starts over. Both count fields can be loaded only while the collector is disabled. Dropping the enable discards any partial bit, byte, block and set.

Top module: `noise_sample_collector`

## Requirements
- R1: After reset `byteValid` and `setDone` are low, and both count fields hold 1, so enabling without a configuration write yields one sample per bit and one block per set.
- R2: While `enable` is high, each cycle's sample is the XOR of `oscBits & oscMask`. With sample count N, each shifted bit is the XOR of N consecutive samples. The first bit shifted into a byte lands in `byteOut[7]` and the last in `byteOut[0]`.
- R3: An oscillator whose `oscMask` bit is 0 has no effect on any output byte.
- R4: A sample count of 0 selects 2^SCNT_W samples per bit (65536 with the default SCNT_W of 16).
- R5: `byteValid` is high for exactly one cycle, in the cycle after the clock edge that shifts in the eighth bit of a byte. `byteOut` holds that byte during the strobe.
- R6: A block is BLOCK_BITS/8 bytes, and a set is `cfgBlockCount` blocks. `setDone` is high for one cycle, in the cycle after the final `byteValid` of a set, and the byte and block counts then restart.
- R7: A block count of 0 selects 256 blocks per set.
- R8: A `cfgWrite` sampled while `enable` is low loads both count fields. A `cfgWrite` sampled while `enable` is high changes nothing.
- R9: A cycle with `enable` low clears the partial bit, the partial byte, and the byte and block counts. No `byteValid` appears while the collector is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Collector run enable |
| oscMask | input | NUM_OSC | Per-oscillator enable mask |
| oscBits | input | NUM_OSC | Sampled oscillator outputs |
| cfgWrite | input | 1 | Load strobe for the count fields |
| cfgSampleCount | input | CFG_W | Samples XORed per shifted bit (0 = 2^SCNT_W) |
| cfgBlockCount | input | CFG_W | Blocks per set (0 = 256) |
| byteOut | output | 8 | Completed raw noise byte |
| byteValid | output | 1 | One-cycle strobe for `byteOut` |
| setDone | output | 1 | One-cycle pulse after the final byte of a set |

## Verification
Two events can meet in one cycle: a configuration write and an enabled collector. The bench provokes this by pulsing `cfgWrite` with new counts in the middle of a run. The bench model keeps the old counts, so every later byte and every later done pulse shows whether the write leaked through. A second collision is an enable drop part-way through a byte. The bench judges it by the absence of a strobe while the collector is disabled, and by the first bytes after re-enable, which must be built from fresh samples only.

// File: rtl/noise_collector_pkg.sv
package noise_collector_pkg;

  // Strobes issued by the control path to the datapath each cycle
  typedef struct packed {
    logic clear;      // drop partial bit and partial byte
    logic accumulate; // fold this cycle's sample into the running XOR
    logic shift;      // close the bit and shift it into the byte
    logic emit;       // this shift completes a byte
    logic last;       // this byte is the final one of a set
  } collectStrobes_t;

endpackage

// File: rtl/noise_collector_ctrl.sv
module noise_collector_ctrl
  import noise_collector_pkg::*;
#(
  parameter int CFG_W           = 8,
  parameter int SCNT_W          = 16,
  parameter int BYTES_PER_BLOCK = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cfgWrite,
  input  logic [CFG_W-1:0] cfgSampleCount,
  input  logic [CFG_W-1:0] cfgBlockCount,
  output collectStrobes_t  strobes
);

  localparam int BYTE_CNT_W = (BYTES_PER_BLOCK > 1) ? $clog2(BYTES_PER_BLOCK) : 1;
  localparam logic [BYTE_CNT_W-1:0] LAST_BYTE = BYTE_CNT_W'(BYTES_PER_BLOCK - 1);

  logic [CFG_W-1:0]      sampleReg, blockReg;
  logic [SCNT_W-1:0]     sampleCnt, sampleLimit;
  logic [CFG_W-1:0]      blockCnt, blockLimit;
  logic [BYTE_CNT_W-1:0] byteCnt;
  logic [2:0]            bitCnt;

  // A zero field wraps to the all-ones limit, giving the maximum count
  assign sampleLimit = SCNT_W'(sampleReg) - SCNT_W'(1);
  assign blockLimit  = blockReg - CFG_W'(1);

  always_comb begin
    strobes.clear      = !enable;
    strobes.shift      = enable && (sampleCnt == sampleLimit);
    strobes.accumulate = enable && !strobes.shift;
    strobes.emit       = strobes.shift && (bitCnt == 3'd7);
    strobes.last       = strobes.emit && (byteCnt == LAST_BYTE) && (blockCnt == blockLimit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleReg <= CFG_W'(1);
      blockReg  <= CFG_W'(1);
    end else if (cfgWrite && !enable) begin
      sampleReg <= cfgSampleCount;
      blockReg  <= cfgBlockCount;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      sampleCnt <= '0;
      bitCnt    <= '0;
      byteCnt   <= '0;
      blockCnt  <= '0;
    end else begin
      if (strobes.shift) begin
        sampleCnt <= '0;
        bitCnt    <= bitCnt + 3'd1;
      end else begin
        sampleCnt <= sampleCnt + SCNT_W'(1);
      end
      if (strobes.emit) begin
        if (byteCnt == LAST_BYTE) begin
          byteCnt  <= '0;
          blockCnt <= (blockCnt == blockLimit) ? '0 : blockCnt + CFG_W'(1);
        end else begin
          byteCnt <= byteCnt + BYTE_CNT_W'(1);
        end
      end
    end
  end

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> ($stable(sampleReg) && $stable(blockReg)));

  // R2
  sample_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> (sampleCnt <= sampleLimit));

endmodule

// File: rtl/noise_collector_dp.sv
module noise_collector_dp
  import noise_collector_pkg::*;
#(
  parameter int NUM_OSC = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_OSC-1:0] oscMask,
  input  logic [NUM_OSC-1:0] oscBits,
  input  collectStrobes_t    strobes,
  output logic [7:0]         byteOut,
  output logic               byteValid,
  output logic               setDone
);

  logic [NUM_OSC-1:0] maskedBits;
  logic               sampleBit, newBit, accBit, lastQ;
  logic [6:0]         partialByte;

  for (genvar g = 0; g < NUM_OSC; g++) begin : gMask
    assign maskedBits[g] = oscBits[g] & oscMask[g];
  end

  assign sampleBit = ^maskedBits;
  assign newBit    = accBit ^ sampleBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accBit      <= 1'b0;
      partialByte <= '0;
      byteOut     <= '0;
      byteValid   <= 1'b0;
      lastQ       <= 1'b0;
      setDone     <= 1'b0;
    end else begin
      byteValid <= strobes.emit;
      lastQ     <= strobes.last;
      setDone   <= lastQ;
      if (strobes.emit) byteOut <= {partialByte, newBit};
      if (strobes.clear) begin
        accBit      <= 1'b0;
        partialByte <= '0;
      end else if (strobes.shift) begin
        accBit      <= 1'b0;
        partialByte <= {partialByte[5:0], newBit};
      end else if (strobes.accumulate) begin
        accBit <= newBit;
      end
    end
  end

  // R6
  done_follows_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    setDone |-> $past(byteValid));

  // R5
  valid_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

endmodule

// File: rtl/noise_sample_collector.sv
module noise_sample_collector
  import noise_collector_pkg::*;
#(
  parameter int NUM_OSC    = 24,
  parameter int CFG_W      = 8,
  parameter int SCNT_W     = 16,
  parameter int BLOCK_BITS = 512
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [NUM_OSC-1:0] oscMask,
  input  logic [NUM_OSC-1:0] oscBits,
  input  logic               cfgWrite,
  input  logic [CFG_W-1:0]   cfgSampleCount,
  input  logic [CFG_W-1:0]   cfgBlockCount,
  output logic [7:0]         byteOut,
  output logic               byteValid,
  output logic               setDone
);

  localparam int BYTES_PER_BLOCK = BLOCK_BITS / 8;

  collectStrobes_t strobes;

  noise_collector_ctrl #(
    .CFG_W(CFG_W), .SCNT_W(SCNT_W), .BYTES_PER_BLOCK(BYTES_PER_BLOCK)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWrite(cfgWrite),
    .cfgSampleCount(cfgSampleCount), .cfgBlockCount(cfgBlockCount),
    .strobes(strobes)
  );

  noise_collector_dp #(.NUM_OSC(NUM_OSC)) uDp (
    .clk(clk), .rstN(rstN), .oscMask(oscMask), .oscBits(oscBits),
    .strobes(strobes), .byteOut(byteOut), .byteValid(byteValid),
    .setDone(setDone)
  );

  // R9
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !byteValid);

endmodule

// File: tb/noise_sample_collector_test.sv
module noise_sample_collector_test;

  localparam int CYC        = 20;
  localparam int NUM_OSC    = 24;
  localparam int CFG_W      = 8;
  localparam int SCNT_W     = 12;
  localparam int BLOCK_BITS = 128;
  localparam int BPB        = BLOCK_BITS / 8;

  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0, cfgWrite = 1'b0;
  logic [NUM_OSC-1:0] oscMask = '0, oscBits = '0;
  logic [CFG_W-1:0] cfgSampleCount = '0, cfgBlockCount = '0;
  logic [7:0] byteOut;
  logic byteValid, setDone;

  always #(CYC/2) clk = ~clk;

  noise_sample_collector #(
    .NUM_OSC(NUM_OSC), .CFG_W(CFG_W), .SCNT_W(SCNT_W), .BLOCK_BITS(BLOCK_BITS)
  ) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .oscMask(oscMask), .oscBits(oscBits),
    .cfgWrite(cfgWrite), .cfgSampleCount(cfgSampleCount), .cfgBlockCount(cfgBlockCount),
    .byteOut(byteOut), .byteValid(byteValid), .setDone(setDone)
  );

  int compared = 0, mismatched = 0;
  string curTag = "R1";
  int curSample = 1, curBlock = 1;
  logic [7:0] expQ[$];
  int mCnt = 0, mBits = 0, mLim = 1, byteSeen = 0, doneSeen = 0, bytesTotal = 0;
  logic mAcc = 1'b0, mSample;
  logic [7:0] mShift = '0, expByte;
  bit doneExp = 0, finished = 0;
  logic [31:0] rnd = 32'h1234_5679;

  task automatic check(bit ok, string tag, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Oscillator stimulus: fresh pseudo-random bits every cycle
  always @(negedge clk) begin
    rnd = rnd ^ (rnd << 13);
    rnd = rnd ^ (rnd >> 17);
    rnd = rnd ^ (rnd << 5);
    oscBits = rnd[NUM_OSC-1:0];
  end

  // Reference model of the byte stream, built from R2/R4/R9
  always @(posedge clk) begin
    if (!rstN || !enable) begin
      mCnt = 0; mAcc = 1'b0; mBits = 0; mShift = '0;
    end else begin
      mSample = ^(oscBits & oscMask);
      mLim = (curSample == 0) ? (1 << SCNT_W) : curSample;
      if (mCnt == mLim - 1) begin
        mShift = {mShift[6:0], mAcc ^ mSample};
        mAcc = 1'b0; mCnt = 0; mBits++;
        if (mBits == 8) begin
          expQ.push_back(mShift);
          mBits = 0;
        end
      end else begin
        mAcc = mAcc ^ mSample;
        mCnt++;
      end
    end
  end

  // Output checker, a quarter period after each edge
  always @(posedge clk) begin
    #5;
    if (rstN && !finished) begin
      // R6: done exactly one cycle after the final byte of a set
      check(setDone === doneExp, "R6 setDone", int'(setDone), int'(doneExp));
      doneExp = 0;
      if (setDone) doneSeen++;
      if (byteValid) begin
        bytesTotal++;
        if (expQ.size() == 0) begin
          check(1'b0, {curTag, " R5 unexpected byteValid"}, 1, 0);
        end else begin
          expByte = expQ.pop_front();
          check(byteOut === expByte, {curTag, " R5 byte"}, int'(byteOut), int'(expByte));
        end
        byteSeen++;
        if (byteSeen % (BPB * ((curBlock == 0) ? 256 : curBlock)) == 0) doneExp = 1;
      end
      if (!enable) byteSeen = 0;
    end
  end

  task automatic runCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setEnable(bit v);
    @(negedge clk);
    enable = v;
  endtask

  task automatic writeCfg(int s, int b, bit accepted);
    @(negedge clk);
    cfgSampleCount = CFG_W'(s);
    cfgBlockCount  = CFG_W'(b);
    cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
    if (accepted) begin
      curSample = s;
      curBlock  = b;
    end
  endtask

  initial begin
    #(CYC * 195000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    runCycles(4);
    rstN = 1'b1;
    runCycles(2);
    // R1: reset state
    check(byteValid === 1'b0, "R1 byteValid after reset", int'(byteValid), 0);
    check(setDone === 1'b0, "R1 setDone after reset", int'(setDone), 0);

    // R1: default counts of one sample per bit and one block per set
    curTag = "R1";
    oscMask = '1;
    setEnable(1);
    runCycles(400);
    setEnable(0);
    runCycles(3);

    // R3: only oscillator 0 contributes, the rest toggle freely
    curTag = "R3";
    oscMask = 24'h000001;
    writeCfg(2, 1, 1);
    setEnable(1);
    runCycles(600);
    setEnable(0);
    runCycles(3);

    // R2: multi-sample XOR with a sparse mask, two blocks per set
    curTag = "R2";
    oscMask = 24'hA5F00F;
    writeCfg(3, 2, 1);
    setEnable(1);
    runCycles(2000);

    // R8: write while running must be ignored
    curTag = "R8";
    writeCfg(5, 3, 0);
    runCycles(1000);
    setEnable(0);
    runCycles(3);
    writeCfg(2, 3, 1);
    setEnable(1);
    runCycles(1000);
    setEnable(0);
    runCycles(3);

    // R9: enable drop mid-byte restarts everything
    curTag = "R9";
    oscMask = '1;
    setEnable(1);
    runCycles(37);
    setEnable(0);
    runCycles(3);
    check(byteValid === 1'b0, "R9 no strobe while disabled", int'(byteValid), 0);
    setEnable(1);
    runCycles(500);
    setEnable(0);
    runCycles(3);

    // R7: block count zero means 256 blocks
    curTag = "R7";
    writeCfg(1, 0, 1);
    doneSeen = 0;
    setEnable(1);
    runCycles(256 * BPB * 8 + 40);
    setEnable(0);
    runCycles(3);
    check(doneSeen == 1, "R7 done pulses for 256-block set", doneSeen, 1);

    // R4: sample count zero means 2^SCNT_W samples per bit
    curTag = "R4";
    writeCfg(0, 1, 1);
    bytesTotal = 0;
    setEnable(1);
    runCycles((1 << SCNT_W) * 8 + 20);
    setEnable(0);
    runCycles(3);
    check(bytesTotal == 1, "R4 bytes at maximum sample count", bytesTotal, 1);
    check(expQ.size() == 0, "R5 pending bytes at end", expQ.size(), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule